// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Power-up Initialization Sequencer

This block keeps an EDO DRAM's contents alive and brings the device up after power-on. On reset it waits out a fixed power-up pause. It then asks the access controller for the strobes and runs a burst of CAS-before-RAS cycles before it declares the memory usable. Because the DRAM supplies the row address itself during these cycles, the sequencer never drives the address bus, WE or OE.

In normal operation an interval timer marks one refresh as owed for every row period, which is the retention time divided by the row count. The default of 4096 rows in 64 ms and the alternative of 2048 rows in 32 ms both give a period of about 15.6 µs. The owed refreshes accumulate in a bounded backlog. While the backlog is non-zero the block raises a request. When it receives a grant it drives CAS and RAS through one complete cycle. When the backlog reaches its limit, an urgent flag tells the arbiter to put refresh ahead of host traffic. A re-initialization input repeats the init burst, without the pause, after the clocks have been stopped for a long time.

Top module: `cbr_refresh_sequencer`

## Requirements
- R1: After reset both strobes are high, the busy output is high and the done pulse is low. No request is raised until PAUSE_US of clock time has elapsed (PAUSE_US*1e6/CLK_PERIOD_PS cycles after reset release).
- R2: When the pause ends, the request and the urgent flag rise together. Exactly INIT_CYCLES CBR cycles follow. After them the init-done output pulses high for exactly one cycle and busy falls.
- R3: In every refresh cycle CAS is already low at least T_CSR_NS before RAS falls. CAS stays low for at least T_CHR_NS after RAS falls.
- R4: RAS stays low for at least T_RAS_NS. It stays high for at least T_RP_NS between cycles. Successive RAS falls are at least T_RC_NS apart.
- R5: After init, one refresh is owed every RETENTION_US*1e6/(CLK_PERIOD_PS*ROWS) cycles, counted from the first cycle of normal operation. The request is high exactly while refreshes are owed.
- R6: The backlog of owed refreshes saturates at MAX_BACKLOG. The urgent flag is high exactly when the backlog is at that limit. With a grant, the backlog is drained one cycle per owed refresh.
- R7: The strobes stay high while the grant is withheld, whatever the backlog.
- R8: A pulse on the re-init input during normal operation starts a new burst of INIT_CYCLES cycles with no pause. Busy and urgent are raised, and the done pulse appears again at the end of the burst.
- R9: Busy is high whenever RAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reinit_i | input | 1 | Request to repeat the init burst |
| ref_grant_i | input | 1 | Arbiter hands the strobes to this block |
| ref_req_o | output | 1 | Refresh or init cycle wanted |
| ref_urgent_o | output | 1 | Refresh must win over host requests |
| busy_o | output | 1 | Init in progress or strobe cycle running |
| init_done_o | output | 1 | One-cycle pulse at the end of an init burst |
| cas_n_o | output | 1 | Column strobe, active low |
| ras_n_o | output | 1 | Row strobe, active low |

## Verification
The hardest state to reach is a backlog at an exact depth, including the saturated one. The backlog can only be built by withholding the grant for several whole row periods, and its depth is not visible at the ports. The stimulus first drains the backlog. It then waits for the request to rise, which marks a timer tick exactly. From that point it withholds the grant for a chosen number of periods plus half a period. The depth is then read out as the urgent flag and as the number of RAS falls seen while the grant drains it.

// File: rtl/cbr_seq_pkg.sv
package cbr_seq_pkg;
  typedef enum logic [2:0] {EN_IDLE, EN_CSR, EN_CHR, EN_RLOW, EN_PRE} eng_state_e;
  typedef enum logic [1:0] {SQ_PAUSE, SQ_INIT, SQ_RUN} seq_state_e;

  // round a time in ns up to whole clock cycles, at least one
  function automatic int ns_to_cyc(int ns, int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c < 1) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/cbr_ref_timer.sv
module cbr_ref_timer #(
  parameter int INTERVAL_CYC = 1562,
  parameter int MAX_BACKLOG  = 8,
  localparam int CW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1,
  localparam int BW = $clog2(MAX_BACKLOG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic          served_i,
  output logic          pending_o,
  output logic          urgent_o
);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CYC - 1);
  localparam logic [BW-1:0] BMAX   = BW'(MAX_BACKLOG);

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] backlog_q;
  logic          tick;

  assign tick = run_i && !restart_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
    end else if (restart_i || !run_i) begin
      cnt_q <= RELOAD;
    end else if (cnt_q == '0) begin
      cnt_q <= RELOAD;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      backlog_q <= '0;
    end else if (restart_i) begin
      backlog_q <= '0;
    end else begin
      unique case ({tick, served_i})
        2'b10:   if (backlog_q != BMAX) backlog_q <= backlog_q + 1'b1;
        2'b01:   if (backlog_q != '0) backlog_q <= backlog_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign pending_o = (backlog_q != '0);
  assign urgent_o  = (backlog_q == BMAX);

  AST_BACKLOG_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backlog_q <= BMAX); // R6
  AST_SERVE_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (served_i && !tick && !restart_i && backlog_q != '0) |=> backlog_q == $past(backlog_q) - 1'b1); // R6
endmodule

// File: rtl/cbr_strobe_engine.sv
module cbr_strobe_engine
  import cbr_seq_pkg::*;
#(
  parameter int CSR_C   = 1,
  parameter int CHR_C   = 1,
  parameter int RREST_C = 4,
  parameter int RP_C    = 3,
  localparam int M1    = (CSR_C > CHR_C) ? CSR_C : CHR_C,
  localparam int M2    = (RREST_C > RP_C) ? RREST_C : RP_C,
  localparam int MAXP  = (M1 > M2) ? M1 : M2,
  localparam int CNT_W = $clog2(MAXP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic done_o,
  output logic cas_n_o,
  output logic ras_n_o
);
  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    unique case (state_q)
      EN_IDLE: if (start_i) begin state_d = EN_CSR; cnt_d = CNT_W'(CSR_C - 1); end
      EN_CSR:  if (cnt_q == '0) begin state_d = EN_CHR; cnt_d = CNT_W'(CHR_C - 1); end
      EN_CHR:  if (cnt_q == '0) begin state_d = EN_RLOW; cnt_d = CNT_W'(RREST_C - 1); end
      EN_RLOW: if (cnt_q == '0) begin state_d = EN_PRE; cnt_d = CNT_W'(RP_C - 1); end
      EN_PRE:  if (cnt_q == '0) state_d = EN_IDLE;
      default: state_d = EN_IDLE;
    endcase
  end

  // strobes registered from next state: glitch-free at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EN_IDLE;
      cnt_q   <= '0;
      cas_n_o <= 1'b1;
      ras_n_o <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cas_n_o <= !(state_d == EN_CSR || state_d == EN_CHR);
      ras_n_o <= !(state_d == EN_CHR || state_d == EN_RLOW);
    end
  end

  assign active_o = (state_q != EN_IDLE);
  assign done_o   = (state_q == EN_PRE) && (cnt_q == '0);

  AST_CAS_LEADS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o))); // R3
  AST_CAS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> (!ras_n_o && $past(!ras_n_o))); // R3
  AST_RAS_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && ras_n_o) |=> !active_o || !cas_n_o); // R3
endmodule

// File: rtl/cbr_refresh_sequencer.sv
module cbr_refresh_sequencer
  import cbr_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int ROWS          = 4096,
  parameter int RETENTION_US  = 64000,
  parameter int PAUSE_US      = 200,
  parameter int INIT_CYCLES   = 8,
  parameter int MAX_BACKLOG   = 8,
  parameter int T_CSR_NS      = 5,
  parameter int T_CHR_NS      = 8,
  parameter int T_RAS_NS      = 50,
  parameter int T_RP_NS       = 30,
  parameter int T_RC_NS       = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reinit_i,
  input  logic ref_grant_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic busy_o,
  output logic init_done_o,
  output logic cas_n_o,
  output logic ras_n_o
);
  localparam int INTERVAL_CYC = int'((longint'(RETENTION_US) * 64'd1000000) /
                                     (longint'(CLK_PERIOD_PS) * longint'(ROWS)));
  localparam int PAUSE_CYC = int'((longint'(PAUSE_US) * 64'd1000000) / longint'(CLK_PERIOD_PS));
  localparam int CSR_C   = ns_to_cyc(T_CSR_NS, CLK_PERIOD_PS);
  localparam int CHR_C   = ns_to_cyc(T_CHR_NS, CLK_PERIOD_PS);
  localparam int RAS_C   = ns_to_cyc(T_RAS_NS, CLK_PERIOD_PS);
  localparam int RREST_C = (RAS_C > CHR_C) ? RAS_C - CHR_C : 1;
  localparam int RP_MIN  = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int RC_GAP  = ns_to_cyc(T_RC_NS, CLK_PERIOD_PS) - RAS_C;
  localparam int RP_C    = (RC_GAP > RP_MIN) ? RC_GAP : RP_MIN;
  localparam int PW      = $clog2(PAUSE_CYC + 1);
  localparam int IW      = $clog2(INIT_CYCLES + 1);

  seq_state_e    state_q;
  logic [PW-1:0] pause_q;
  logic [IW-1:0] init_cnt_q;
  logic          reinit_pend_q;
  logic          done_q;
  logic          eng_start, eng_active, eng_done;
  logic          owed, at_limit, in_run;

  assign in_run = (state_q == SQ_RUN);

  cbr_ref_timer #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .MAX_BACKLOG  (MAX_BACKLOG)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (in_run),
    .restart_i (!in_run),
    .served_i  (eng_done && in_run),
    .pending_o (owed),
    .urgent_o  (at_limit)
  );

  cbr_strobe_engine #(
    .CSR_C   (CSR_C),
    .CHR_C   (CHR_C),
    .RREST_C (RREST_C),
    .RP_C    (RP_C)
  ) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (eng_start),
    .active_o (eng_active),
    .done_o   (eng_done),
    .cas_n_o  (cas_n_o),
    .ras_n_o  (ras_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= SQ_PAUSE;
      pause_q       <= PW'(PAUSE_CYC - 1);
      init_cnt_q    <= '0;
      reinit_pend_q <= 1'b0;
      done_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_PAUSE: begin
          if (pause_q == '0) begin
            state_q    <= SQ_INIT;
            init_cnt_q <= '0;
          end else begin
            pause_q <= pause_q - 1'b1;
          end
        end
        SQ_INIT: begin
          if (eng_done) begin
            if (init_cnt_q == IW'(INIT_CYCLES - 1)) begin
              state_q <= SQ_RUN;
              done_q  <= 1'b1;
            end else begin
              init_cnt_q <= init_cnt_q + 1'b1;
            end
          end
        end
        SQ_RUN: begin
          // re-init waits for any running cycle to finish
          if (reinit_pend_q && !eng_active) begin
            state_q       <= SQ_INIT;
            init_cnt_q    <= '0;
            reinit_pend_q <= 1'b0;
          end else if (reinit_i) begin
            reinit_pend_q <= 1'b1;
          end
        end
        default: state_q <= SQ_PAUSE;
      endcase
    end
  end

  assign ref_req_o    = (state_q == SQ_INIT) || (in_run && owed);
  assign ref_urgent_o = (state_q == SQ_INIT) || (in_run && at_limit);
  assign eng_start    = ref_req_o && ref_grant_i && !eng_active;
  assign busy_o       = !in_run || eng_active;
  assign init_done_o  = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> !init_done_o); // R2
  AST_URGENT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> ref_req_o); // R6
  AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_req_o |-> (ras_n_o && cas_n_o)); // R7
  AST_BUSY_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> busy_o); // R9
  AST_NO_START_IN_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_PAUSE) |-> (!ref_req_o && cas_n_o)); // R1
endmodule

// File: tb/cbr_refresh_sequencer_test.sv
module cbr_refresh_sequencer_test;
  localparam int PS      = 10000;
  localparam int ROWS    = 64;
  localparam int RET_US  = 128;   // 200-cycle row period
  localparam int PAUSEUS = 2;     // 200-cycle pause
  localparam int INITN   = 8;
  localparam int MAXB    = 4;
  localparam int PERIOD  = RET_US * 100 / ROWS;
  localparam int PAUSE_C = PAUSEUS * 100;
  localparam int RAS_C   = 5;     // 50 ns
  localparam int RP_C    = 3;     // 30 ns
  localparam int RC_C    = 8;     // 80 ns
  localparam int VN      = 4;
  localparam int VEC_TICKS [VN] = '{1, 2, 4, 6};
  localparam bit VEC_URG   [VN] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam int VEC_CNT   [VN] = '{1, 2, 4, 4};

  logic clk = 1'b0, rst_n = 1'b0, reinit = 1'b0, grant = 1'b0;
  logic req, urgent, busy, done, cas_n, ras_n;

  cbr_refresh_sequencer #(
    .CLK_PERIOD_PS (PS), .ROWS (ROWS), .RETENTION_US (RET_US),
    .PAUSE_US (PAUSEUS), .INIT_CYCLES (INITN), .MAX_BACKLOG (MAXB)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .reinit_i (reinit), .ref_grant_i (grant),
    .ref_req_o (req), .ref_urgent_o (urgent), .busy_o (busy),
    .init_done_o (done), .cas_n_o (cas_n), .ras_n_o (ras_n)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, fall_cnt = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // strobe timing monitor
  logic p_ras = 1'b1, p_cas = 1'b1;
  int low_len = 0, high_len = 0, since_fall = 0;
  bit seen_fall = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      since_fall++;
      if (p_ras && !ras_n) begin
        chk(!p_cas && !cas_n, "R3 cas low before and at ras fall", int'(p_cas), 0);
        chk(high_len >= RP_C, "R4 ras precharge", high_len, RP_C);
        if (seen_fall) chk(since_fall >= RC_C, "R4 ras fall spacing", since_fall, RC_C);
        seen_fall = 1'b1;
        since_fall = 0;
        high_len = 0;
        fall_cnt++;
      end
      if (!p_ras && ras_n) begin
        chk(low_len >= RAS_C, "R4 ras low width", low_len, RAS_C);
        low_len = 0;
      end
      if (!ras_n) begin
        low_len++;
        chk(busy, "R9 busy while ras low", int'(busy), 1);
      end else begin
        high_len++;
      end
      p_ras = ras_n;
      p_cas = cas_n;
    end
  end

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      seen = done;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit seen, early;
    int fc0;
    grant = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n, "R1 strobes high in reset", int'({ras_n, cas_n}), 3);
    chk(busy && !done && !req, "R1 busy/done/req in reset", int'({busy, done, req}), 4);
    rst_n = 1'b1;
    early = 1'b0;
    for (int k = 1; k <= PAUSE_C; k++) begin
      @(negedge clk);
      if (k < PAUSE_C && (req || !cas_n)) early = 1'b1;
      if (k == PAUSE_C - 1) chk(!req, "R1 no request before pause end", int'(req), 0);
      if (k == PAUSE_C) begin
        chk(req, "R2 request at pause end", int'(req), 1);
        chk(urgent, "R2 urgent during init", int'(urgent), 1);
      end
    end
    chk(!early, "R1 quiet during pause", int'(early), 0);

    // R2 init burst
    fc0 = fall_cnt;
    wait_done(seen);
    chk(seen, "R2 init done pulse seen", int'(seen), 1);
    chk(fall_cnt - fc0 == INITN, "R2 init cycle count", fall_cnt - fc0, INITN);
    chk(!busy, "R2 busy low after init", int'(busy), 0);
    grant = 1'b0;

    // R5 row period from first run cycle
    for (int k = 1; k <= PERIOD; k++) begin
      @(negedge clk);
      if (k == 1) chk(!done, "R2 done is one cycle", int'(done), 0);
      if (k == PERIOD - 1) chk(!req, "R5 no request before period", int'(req), 0);
      if (k == PERIOD) chk(req, "R5 request after one period", int'(req), 1);
    end

    // backlog vectors: request just rose, backlog is one
    for (int v = 0; v < VN; v++) begin
      repeat ((VEC_TICKS[v] - 1) * PERIOD + PERIOD / 2) @(negedge clk);
      chk(urgent == VEC_URG[v], "R6 urgent at backlog depth", int'(urgent), int'(VEC_URG[v]));
      chk(ras_n && cas_n, "R7 strobes idle without grant", int'({ras_n, cas_n}), 3);
      chk(req, "R5 request while owed", int'(req), 1);
      fc0 = fall_cnt;
      grant = 1'b1;
      for (int i = 0; i < 500 && req; i++) @(negedge clk);
      @(negedge clk);
      chk(fall_cnt - fc0 == VEC_CNT[v], "R6 cycles to drain backlog", fall_cnt - fc0, VEC_CNT[v]);
      chk(!busy && !req, "R9 idle after drain", int'({busy, req}), 0);
      grant = 1'b0;
      if (v < VN - 1) begin
        for (int i = 0; i < 2 * PERIOD && !req; i++) @(negedge clk);
        chk(req, "R5 next tick raises request", int'(req), 1);
      end
    end

    // R8 re-init
    grant = 1'b1;
    fc0 = fall_cnt;
    reinit = 1'b1;
    @(negedge clk);
    reinit = 1'b0;
    @(negedge clk);
    chk(busy && urgent, "R8 busy and urgent after reinit", int'({busy, urgent}), 3);
    wait_done(seen);
    chk(seen, "R8 done pulse after reinit", int'(seen), 1);
    chk(fall_cnt - fc0 == INITN, "R8 reinit cycle count", fall_cnt - fc0, INITN);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule